// File: doc/BRIEF.md
# Twin-Predicated Element Move Sequencer

This controller walks a vector move element by element while two independent predicate masks govern it, one on the source side and one on the destination side. It keeps a source element index and a destination element index that advance separately. Each index can jump over masked-off elements, and it moves at all only if its side is a vector. Every busy cycle it either issues one element transfer or ends the sequence. A transfer names the source element, the destination element, whether the destination is written, and whether the value written is forced to zero.

A datapath uses the transfer stream to read and write a register file. A single `start` cycle captures the vector length, both masks, and the zeroing and vector/scalar flag for each side. The sequencer then runs on its own and raises `done` for one cycle when it finishes. It does not move data and has no notion of element width.

Top module: `twin_pred_seq`

## Requirements
- R1: After reset `busy`, `done` and `xfer_valid` are low.
- R2: When a side is a vector with its zeroing flag off, its index skips past clear bits of that side's predicate, so every transfer names an element whose predicate bit is 1.
- R3: `xfer_we` is 1 when the destination predicate bit is 1 or destination zeroing is on. A clear destination bit with destination zeroing on sets `xfer_zero`. With both zeroing flags off and a clear destination bit, `xfer_we` is 0.
- R4: With source zeroing on and a clear source predicate bit, `xfer_zero` is 1. With both zeroing flags on, a destination element is zeroed wherever either bit is clear.
- R5: After a transfer, the source index advances by one only if the source is a vector, and the destination index advances only if the destination is a vector. A scalar side stays at element 0.
- R6: A scalar destination ends the sequence in the same cycle as its first transfer with `xfer_we` = 1.
- R7: The sequence ends without a transfer when either index, after any skipping, is at or beyond VL. With VL = 0 it ends in its first busy cycle. VL = MAX_VL with the last mask bit set reaches element MAX_VL-1.
- R8: `done` is high for exactly one cycle, in the last busy cycle. At most one transfer is issued per cycle, and only while `busy`.
- R9: `start` has no effect while `busy` is high. Configuration applied during a run does not change its transfers.
- R10: When source and destination are both scalar, the sequence ends after its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (sampled only while idle) |
| vl | input | $clog2(MAX_VL+1) | Vector length, clamped to MAX_VL |
| src_pred | input | MAX_VL | Source predicate mask |
| dst_pred | input | MAX_VL | Destination predicate mask |
| src_zero | input | 1 | Source zeroing mode |
| dst_zero | input | 1 | Destination zeroing mode |
| src_vec | input | 1 | Source is a vector (1) or scalar (0) |
| dst_vec | input | 1 | Destination is a vector (1) or scalar (0) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| xfer_valid | output | 1 | Element transfer issued this cycle |
| xfer_src_idx | output | $clog2(MAX_VL) | Source element index |
| xfer_dst_idx | output | $clog2(MAX_VL) | Destination element index |
| xfer_we | output | 1 | Destination element is written |
| xfer_zero | output | 1 | Written value is forced to zero |

## Verification
The bench builds the sequencer with its default MAX_VL of 64. This makes full 64-bit masks available, as well as the top element 63 and a vector length of exactly 64. The stimulus includes an index skipping straight to the end of the vector, every vector/scalar pairing, and every zeroing combination. A scoreboard predicts each transfer and compares it against the design's transfer stream in order.

// File: rtl/twin_pred_seq.sv
module twin_pred_seq #(
  parameter int MAX_VL = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [$clog2(MAX_VL+1)-1:0]  vl,
  input  logic [MAX_VL-1:0]            src_pred,
  input  logic [MAX_VL-1:0]            dst_pred,
  input  logic                         src_zero,
  input  logic                         dst_zero,
  input  logic                         src_vec,
  input  logic                         dst_vec,
  output logic                         busy,
  output logic                         done,
  output logic                         xfer_valid,
  output logic [$clog2(MAX_VL)-1:0]    xfer_src_idx,
  output logic [$clog2(MAX_VL)-1:0]    xfer_dst_idx,
  output logic                         xfer_we,
  output logic                         xfer_zero
);
  localparam int IW = $clog2(MAX_VL);
  localparam int CW = $clog2(MAX_VL+1);
  localparam logic [CW-1:0] VL_MAX = CW'(MAX_VL);

  logic [CW-1:0]     i_q, j_q, vl_q;
  logic [MAX_VL-1:0] sp_q, dp_q;
  logic              sz_q, dz_q, sv_q, dv_q;

  function automatic logic [CW-1:0] next_set(input logic [MAX_VL-1:0] m,
                                             input logic [CW-1:0] from);
    logic [CW-1:0] r;
    r = VL_MAX;
    for (int k = MAX_VL-1; k >= 0; k--)
      if (CW'(k) >= from && m[k]) r = CW'(k);
    return r;
  endfunction

  logic [CW-1:0] i_n, j_n;
  logic          end_hit, step, sbit, dbit, we, zro, last;

  assign i_n     = (sv_q && !sz_q) ? next_set(sp_q, i_q) : i_q;
  assign j_n     = (dv_q && !dz_q) ? next_set(dp_q, j_q) : j_q;
  assign end_hit = (i_n >= vl_q) || (j_n >= vl_q);
  assign step    = busy && !end_hit;
  assign sbit    = sp_q[i_n[IW-1:0]];
  assign dbit    = dp_q[j_n[IW-1:0]];
  assign we      = dbit || dz_q;
  assign zro     = (dz_q && !dbit) || (sz_q && !sbit);
  assign last    = step && ((!dv_q && we) || (!sv_q && !dv_q));

  assign done         = busy && (end_hit || last);
  assign xfer_valid   = step;
  assign xfer_src_idx = i_n[IW-1:0];
  assign xfer_dst_idx = j_n[IW-1:0];
  assign xfer_we      = step && we;
  assign xfer_zero    = step && zro;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      i_q  <= '0;
      j_q  <= '0;
      vl_q <= '0;
      sp_q <= '0;
      dp_q <= '0;
      sz_q <= 1'b0;
      dz_q <= 1'b0;
      sv_q <= 1'b0;
      dv_q <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        i_q  <= '0;
        j_q  <= '0;
        vl_q <= (vl > VL_MAX) ? VL_MAX : vl;
        sp_q <= src_pred;
        dp_q <= dst_pred;
        sz_q <= src_zero;
        dz_q <= dst_zero;
        sv_q <= src_vec;
        dv_q <= dst_vec;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      i_q <= i_n + CW'(sv_q);
      j_q <= j_n + CW'(dv_q);
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> busy);
  // R3
  no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_we) |-> (!dz_q && !dst_pred[xfer_dst_idx] && !dv_q));
  // R2
  src_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && sv_q && !sz_q) |-> sp_q[xfer_src_idx]);
  // R5
  scalar_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !sv_q) |-> (xfer_src_idx == '0));
  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> ({1'b0, xfer_src_idx} < vl_q && {1'b0, xfer_dst_idx} < vl_q));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(vl_q) && $stable(sp_q) && $stable(dp_q)));
endmodule

// File: tb/tb_twin_pred_seq.sv
module tb_twin_pred_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL = 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0]  vl = '0;
  logic [63:0] src_pred = '0, dst_pred = '0;
  logic src_zero = 1'b0, dst_zero = 1'b0, src_vec = 1'b0, dst_vec = 1'b0;
  logic busy, done, xfer_valid, xfer_we, xfer_zero;
  logic [5:0] xfer_src_idx, xfer_dst_idx;

  twin_pred_seq #(.MAX_VL(MAX_VL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_pred(src_pred), .dst_pred(dst_pred),
    .src_zero(src_zero), .dst_zero(dst_zero),
    .src_vec(src_vec), .dst_vec(dst_vec),
    .busy(busy), .done(done), .xfer_valid(xfer_valid),
    .xfer_src_idx(xfer_src_idx), .xfer_dst_idx(xfer_dst_idx),
    .xfer_we(xfer_we), .xfer_zero(xfer_zero));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [5:0] s;
    logic [5:0] d;
    logic       we;
    logic       z;
  } item_t;

  item_t exp_q[$];
  string cur_tag = "R1";
  int checks = 0, fails = 0;
  logic prev_done = 1'b0;

  task automatic check(string tag, logic ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) check("R8", 1'b0, "done longer than one cycle", 1, 0);
      prev_done = done;
      if (xfer_valid) begin
        item_t got, e;
        got = '{xfer_src_idx, xfer_dst_idx, xfer_we, xfer_zero};
        if (exp_q.size() == 0) begin
          check(cur_tag, 1'b0, "unexpected transfer", got, 0);
        end else begin
          e = exp_q.pop_front();
          check(cur_tag, got == e, "transfer {src,dst,we,zero}", got, e);
        end
      end
    end
  end

  task automatic run(string tag, int v, logic [63:0] sp, logic [63:0] dp,
                     bit sz, bit dz, bit sv, bit dv, bit poke);
    int i = 0, j = 0;
    bit sb, db, w, z;
    forever begin
      if (sv && !sz) while (i < v && !sp[i]) i++;
      if (dv && !dz) while (j < v && !dp[j]) j++;
      if (i >= v || j >= v) break;
      sb = sp[i]; db = dp[j];
      w = db | dz;
      z = (dz & !db) | (sz & !sb);
      exp_q.push_back('{6'(i), 6'(j), w, z});
      if (!dv && w) break;
      if (!sv && !dv) break;
      i += int'(sv);
      j += int'(dv);
    end
    cur_tag = tag;
    @(negedge clk);
    vl = 7'(v); src_pred = sp; dst_pred = dp;
    src_zero = sz; dst_zero = dz; src_vec = sv; dst_vec = dv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke && !done) begin
      vl = 7'd3; src_pred = '0; dst_pred = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(posedge clk);
    #1;
    check(tag, exp_q.size() == 0, "transfers missing at end", exp_q.size(), 0);
    check("R8", !busy && !done, "idle after done", {busy, done}, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 1'b0, "run hung", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 3);
    // R1
    check("R1", !busy && !done && !xfer_valid, "reset state",
          {busy, done, xfer_valid}, 0);
    rst_n = 1'b1;
    // R8 plain full-mask vector run
    run("R8", 8, '1, '1, 0, 0, 1, 1, 0);
    // R2 independent skips on both sides
    run("R2", 16, 64'h0000_0000_0000_A5C3, 64'h0000_0000_0000_3F18, 0, 0, 1, 1, 0);
    // R3 destination zeroing, no dst skip
    run("R3", 10, '1, 64'h0000_0000_0000_0155, 0, 1, 1, 1, 0);
    // R4 source zeroing passes zero for clear source bits
    run("R4", 12, 64'h0000_0000_0000_0F0F, '1, 1, 0, 1, 1, 0);
    // R4 both zeroing: zero where either bit clear
    run("R4", 12, 64'h0000_0000_0000_0AAA, 64'h0000_0000_0000_0CCC, 1, 1, 1, 1, 0);
    // R5 scalar source splat into vector
    run("R5", 6, 64'h1, 64'h0000_0000_0000_002D, 0, 0, 0, 1, 0);
    // R6 scalar destination ends at first write
    run("R6", 20, 64'h0000_0000_0000_0F00, 64'h1, 0, 0, 1, 0, 0);
    // R3 scalar destination with clear bit: steps issue no write
    run("R3", 9, 64'h0000_0000_0000_0111, 64'h0, 0, 0, 1, 0, 0);
    // R6 scalar destination zeroed once then ends
    run("R6", 9, '1, 64'h0, 0, 1, 1, 0, 0);
    // R7 zero length
    run("R7", 0, '1, '1, 0, 0, 1, 1, 0);
    // R7 source skip runs past VL
    run("R7", 8, 64'h0000_0000_0000_0F00, '1, 0, 0, 1, 1, 0);
    // R7 full length reaches top element
    run("R7", 64, 64'h8000_0000_0000_0001, 64'hC000_0000_0000_0000, 0, 0, 1, 1, 0);
    // R10 both scalar
    run("R10", 5, 64'h0, 64'h0, 0, 0, 0, 0, 0);
    // R9 start while busy is ignored
    run("R9", 32, '1, '1, 0, 0, 1, 1, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule